// File: doc/BRIEF.md
# Daisy-Chained Bus Arbiter

A row of identical agent cells decides which agent may use a shared bus. Priority moves along the row. Agent 0 sits at the head of the row and ranks highest. The head cell's priority input is tied active. A cell that has no pending request passes its priority input on to the next cell unchanged. A cell that has a request pending blocks the priority output for every cell below it. After the row settles, at most one cell sees priority arrive without passing it on, and that cell holds priority.

Ownership of the bus is shown by a shared busy line, modelled as the OR of each cell's busy drive. The priority holder takes the bus only when the busy line is low at a clock edge. It keeps the bus until it signals that its transfer is complete. No other agent can pre-empt it, whatever its rank.

Top module: `chain_arbiter`

## Requirements
- R1: While rst_ni is low, and at the first edge after it is released, grant_o is all zeros and busy_o is low.
- R2: Each clock edge registers req_i. prio_o then has exactly the bit of the lowest-numbered agent whose registered request is set, with bit 0 as highest priority. chain_free_o is high exactly when no registered request is set.
- R3: When several requests are registered at once, prio_o still has at most one bit set, and only the lowest-numbered requester appears there.
- R4: grant_o[i] goes high at an edge only if, just before that edge, prio_o[i] was high and busy_o was low.
- R5: At most one grant_o bit is ever set, and busy_o is high exactly when some grant_o bit is set.
- R6: Once an agent holds the grant, it keeps it while its own done_i bit is low, even when a higher-priority request arrives.
- R7: done_i[i], sampled high at an edge while agent i holds the grant, clears the grant at that edge. No agent is granted at that same edge, so the bus is idle for at least one cycle before the next owner.
- R8: done_i bits of agents that do not hold the grant have no effect on grant_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Per-agent bus request, level |
| done_i | input | N | Per-agent end-of-transfer pulse |
| grant_o | output | N | One-hot bus owner |
| prio_o | output | N | One-hot current priority holder |
| busy_o | output | 1 | Resolved shared busy line |
| chain_free_o | output | 1 | Priority reaches the end of the chain unclaimed |

## Verification
All sixteen request patterns of the four-agent default are applied from an idle bus. The agents are then served one by one until none remain. This shows whether the lowest-numbered requester wins, and whether each release opens a one-cycle gap before the next owner. A higher-priority request that arrives while a lower agent owns the bus tells a non-pre-emptive arbiter apart from one that pre-empts. done_i pulses on agents that do not own the bus show whether a release is wrongly taken from the wrong agent.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_HELD = 1'b1
  } own_e;
endpackage

// File: rtl/arb_cell.sv
module arb_cell
  import arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic done_i,
  input  logic pri_in_i,
  input  logic bus_busy_i,
  output logic pri_out_o,
  output logic prio_o,
  output logic busy_drv_o
);
  logic req_q;
  own_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  // a pending request blocks priority for everyone downstream
  assign pri_out_o = pri_in_i & ~req_q;
  assign prio_o    = pri_in_i & ~pri_out_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      OWN_IDLE: if (prio_o && !bus_busy_i) st_d = OWN_HELD;
      OWN_HELD: if (done_i) st_d = OWN_IDLE;
      default:  st_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= OWN_IDLE;
    else         st_q <= st_d;
  end

  assign busy_drv_o = (st_q == OWN_HELD);
endmodule

// File: rtl/busy_or.sv
module busy_or #(
  parameter int N = 4
) (
  input  logic [N-1:0] drv_i,
  output logic         busy_o
);
  assign busy_o = |drv_i;
endmodule

// File: rtl/chain_arbiter.sv
module chain_arbiter #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] done_i,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] prio_o,
  output logic         busy_o,
  output logic         chain_free_o
);
  localparam int CHAIN_W = N + 1;

  logic [CHAIN_W-1:0] pri_chain;
  logic [N-1:0]       busy_drv_w;

  assign pri_chain[0] = 1'b1;  // head: nothing above wants the bus

  for (genvar g = 0; g < N; g++) begin : g_agent
    arb_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i[g]),
      .done_i     (done_i[g]),
      .pri_in_i   (pri_chain[g]),
      .bus_busy_i (busy_o),
      .pri_out_o  (pri_chain[g+1]),
      .prio_o     (prio_o[g]),
      .busy_drv_o (busy_drv_w[g])
    );
  end

  busy_or #(.N(N)) u_busy (
    .drv_i  (busy_drv_w),
    .busy_o (busy_o)
  );

  assign grant_o      = busy_drv_w;
  assign chain_free_o = pri_chain[CHAIN_W-1];
endmodule

// File: rtl/chain_arbiter_chk.sv
module chain_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] done_i,
  input logic [N-1:0] grant_o,
  input logic [N-1:0] prio_o,
  input logic         busy_o,
  input logic         chain_free_o,
  input logic [N-1:0] busy_drv_w
);
  p_single_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_drv_w));

  p_busy_matches_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (grant_o != '0));

  p_prio_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(prio_o));

  p_free_iff_none_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_free_o == (prio_o == '0));

  p_take_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ((grant_o & ~$past(grant_o)) == '0));

  p_take_prio_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & ~$past(grant_o) & ~$past(prio_o)) == '0));

  // R8: done on other agents must not disturb the owner either
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && (grant_o & done_i) == '0) |=> grant_o == $past(grant_o));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & done_i) != '0) |=> grant_o == '0);
endmodule

bind chain_arbiter chain_arbiter_chk #(.N(N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .done_i       (done_i),
  .grant_o      (grant_o),
  .prio_o       (prio_o),
  .busy_o       (busy_o),
  .chain_free_o (chain_free_o),
  .busy_drv_w   (busy_drv_w)
);

// File: tb/tb_chain_arbiter.sv
`timescale 1ns/1ps
module tb_chain_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] grant_o, prio_o;
  logic         busy_o, chain_free_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] m_req = '0;
  logic [N-1:0] m_own = '0;

  always #4 clk = ~clk;

  chain_arbiter #(.N(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .done_i(done),
    .grant_o(grant_o), .prio_o(prio_o), .busy_o(busy_o), .chain_free_o(chain_free_o)
  );

  function automatic logic [N-1:0] lowbit(logic [N-1:0] x);
    return x & (~x + 1'b1);
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // inputs are set 1 ns after an edge; model advances, then outputs checked after the edge
  task automatic step(string gtag);
    logic [N-1:0] cur_prio;
    cur_prio = lowbit(m_req);
    if (m_own != '0) begin
      if ((m_own & done) != '0) m_own = '0;
    end else begin
      m_own = cur_prio;
    end
    m_req = req;
    @(posedge clk); #1;
    chk(gtag, grant_o, m_own);
    chk("R5 busy", N'(busy_o), N'(m_own != '0));
    chk(($countones(m_req) > 1) ? "R3 single priority" : "R2 priority select",
        prio_o, lowbit(m_req));
    chk("R2 chain free", N'(chain_free_o), N'(m_req == '0));
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset grant", grant_o, '0);
    chk("R1 reset busy", N'(busy_o), '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 first edge grant", grant_o, '0);

    // full sweep of request patterns, serving every requester in turn
    for (int p = 0; p < (1 << N); p++) begin
      req  = N'(p);
      done = '0;
      step("R4 grant");
      step("R4 grant");
      repeat (2) step("R6 hold");
      for (int k = 0; k < 3 * N + 4; k++) begin
        if (m_own == '0 && req == '0 && m_req == '0) break;
        if (m_own != '0) begin
          done = m_own;
          req  = req & ~m_own;
          step("R7 release");
        end else begin
          step("R4 next grant");
        end
        done = '0;
      end
      step("R7 idle");
    end

    // higher priority arrives while the lowest agent owns the bus
    req = 4'b1000;
    step("R4 grant");
    step("R4 grant");
    chk("R4 low agent owns", grant_o, 4'b1000);
    req = 4'b1001;
    repeat (3) step("R6 no preempt");
    chk("R6 owner kept", grant_o, 4'b1000);

    done = 4'b0011;
    step("R8 ignored done");
    done = 4'b0110;
    step("R8 ignored done");
    chk("R8 owner kept", grant_o, 4'b1000);

    done = 4'b1000;
    req  = 4'b0001;
    step("R7 release gap");
    chk("R7 idle after release", grant_o, '0);
    done = '0;
    step("R4 waiter granted");
    chk("R4 head agent owns", grant_o, 4'b0001);
    done = 4'b0001;
    req  = '0;
    step("R7 release");
    done = '0;
    step("R7 idle");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule